// File: doc/BRIEF.md
# Auto-Mode I2C Master Sequencer

This block runs a complete I2C master transaction after a single configuration write. It produces the start (or repeated start) condition, sends a 7-bit target address with the direction bit, and moves a programmed number of bytes. In a write, bytes come from a transmit FIFO. In a read, bytes go into a receive FIFO. At the end it either generates a stop condition or leaves the bus held so that the next transaction opens with a repeated start. The usual pattern is a register-address write without stop, followed by a read with stop.

Bus timing is not generated here. An external tick input paces the engine, and each bus bit takes four ticks. The engine never corrupts data when the FIFOs are not ready: it holds SCL low while the transmit FIFO is empty or the receive FIFO is full. An optional stall timeout aborts such a wait.

Each transaction ends in exactly one outcome pulse, and busy falls in the same cycle. The possible outcomes are:
- success;
- no device (address not acknowledged);
- data not acknowledged;
- arbitration lost;
- timeout.

A soft reset input returns the engine to idle with the bus released.

Top module: `i2c_auto_master`

## Requirements
- R1: A configuration write (`cfg_we`) is decoded as follows: byte count in bits 15:0, direction in bit 16 (1 = read), stop-after-transfer in bit 17, run in bit 31. Only bits 16:10 of `addr_word` form the 7-bit address that is sent; its other bits are ignored. A configuration write while busy or while a run is pending has no effect.
- R2: An accepted write with the run bit set raises `run_pend` in the next cycle. `run_pend` clears when the sequence starts, and it is never high while `busy` is high.
- R3: A run request with a byte count of zero is dropped: `run_pend` stays low and there is no bus activity and no outcome.
- R4: In a write, the address byte is {address, 0}. Then `count` bytes are popped from the transmit FIFO in order and sent MSB first.
- R5: In a read, the address byte is {address, 1}. Each received byte is pushed to the receive FIFO. The master acknowledges (drives SDA low in the ninth bit) every byte except the last, which it leaves unacknowledged.
- R6: With stop-after-transfer set, the transfer ends with a stop condition. The success pulse appears only after the stop completes, with both lines released and `busy` low.
- R7: With stop-after-transfer clear, the transfer ends with SCL held low, SDA released and `bus_held` high. The success pulse appears at that point, and the next transfer begins with a repeated start.
- R8: If the address byte is not acknowledged, a stop is generated and `ev_nodev` pulses.
- R9: If a data byte of a write is not acknowledged, a stop is generated and `ev_nack` pulses. No further byte is popped.
- R10: If SDA reads low while the engine drives it high, `ev_arb` pulses and both lines are released with no stop.
- R11: The engine stalls with SCL held low while the transmit FIFO is empty (write) or the receive FIFO is full (read).
  - With `tmo_dis` low, `TOUT_CYC` stalled cycles abort the transfer with a stop and an `ev_tout` pulse.
  - With `tmo_dis` high, the stall lasts until the FIFO becomes ready.
- R12: A soft reset (`srst`) returns the engine to idle in one cycle. It releases both lines and clears `busy` and `run_pend`, and no outcome pulses.
- R13: Every started transaction produces exactly one outcome pulse, and it occurs in the cycle in which `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| srst | input | 1 | Soft reset, returns engine to idle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_word | input | 32 | Count[15:0], read[16], stop[17], run[31] |
| addr_word | input | 32 | Target address; bits 16:10 used |
| tmo_dis | input | 1 | 1 disables the stall timeout |
| tick | input | 1 | Quarter-bit pacing strobe |
| tx_data | input | 8 | Transmit FIFO head |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_pop | output | 1 | Transmit FIFO pop |
| rx_data | output | 8 | Byte to push into receive FIFO |
| rx_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Receive FIFO push |
| sda_i | input | 1 | SDA line level |
| scl_lo | output | 1 | 1 pulls SCL low |
| sda_lo | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Transaction in progress |
| run_pend | output | 1 | Run request accepted, not yet started |
| bus_held | output | 1 | Bus held after a transfer without stop |
| ev_ok | output | 1 | Success pulse |
| ev_nodev | output | 1 | Address not acknowledged pulse |
| ev_nack | output | 1 | Data not acknowledged pulse |
| ev_arb | output | 1 | Arbitration lost pulse |
| ev_tout | output | 1 | Stall timeout pulse |

## Verification
Some properties are checked on every cycle by the assertions:
- at most one outcome pulse, always with `busy` low;
- no pending run while busy;
- SCL held low during any FIFO stall;
- FIFO pops only in writes and pushes only in reads;
- the line state that each outcome leaves behind (both released after a stop or an arbitration loss, SCL held low after a transfer without stop);
- the idle state after a soft reset.

Other behaviour shows up only in the bench scenarios against a bus-target model:
- the byte order on the bus;
- the last-byte acknowledge pattern in reads;
- the repeated start after a held bus;
- the outcome classification for address and data refusals;
- the difference between an enabled and a disabled timeout.

// File: rtl/i2c_auto_master.sv
module i2c_auto_master #(
  parameter int CNT_W    = 16,
  parameter int TOUT_CYC = 300
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        srst,
  input  logic        cfg_we,
  input  logic [31:0] cfg_word,
  input  logic [31:0] addr_word,
  input  logic        tmo_dis,
  input  logic        tick,
  input  logic [7:0]  tx_data,
  input  logic        tx_empty,
  output logic        tx_pop,
  output logic [7:0]  rx_data,
  input  logic        rx_full,
  output logic        rx_push,
  input  logic        sda_i,
  output logic        scl_lo,
  output logic        sda_lo,
  output logic        busy,
  output logic        run_pend,
  output logic        bus_held,
  output logic        ev_ok,
  output logic        ev_nodev,
  output logic        ev_nack,
  output logic        ev_arb,
  output logic        ev_tout
);
  localparam int TW = $clog2(TOUT_CYC + 1);
  localparam logic [1:0] RES_OK = 2'd0, RES_NODEV = 2'd1, RES_NACK = 2'd2, RES_TOUT = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_LOAD, S_PUSH, S_STOP} st_t;

  st_t              st;
  logic [1:0]       ph;
  logic [3:0]       bitn;
  logic [7:0]       sh;
  logic             is_addr, rd, stp, own, nak, c_rd, c_stp;
  logic [CNT_W-1:0] remain, c_len;
  logic [6:0]       tgt;
  logic [1:0]       res;
  logic [TW-1:0]    tmo_cnt;

  wire stall    = (st == S_LOAD && tx_empty) || (st == S_PUSH && rx_full);
  wire tmo_hit  = stall && !tmo_dis && (tmo_cnt == TW'(TOUT_CYC - 1));
  wire cfg_take = cfg_we && !busy && !run_pend;
  wire data_bit = (bitn < 4'd8);
  wire mdrv     = data_bit ? (is_addr || !rd) : (!is_addr && rd);
  wire last     = (remain == CNT_W'(1));
  wire mlow     = data_bit ? !sh[7] : !last;

  assign tx_pop  = (st == S_LOAD) && !tx_empty;
  assign rx_push = (st == S_PUSH) && !rx_full;
  assign rx_data = sh;

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      st <= S_IDLE; ph <= '0; bitn <= '0; sh <= '0;
      is_addr <= 1'b0; rd <= 1'b0; stp <= 1'b0; own <= 1'b0; nak <= 1'b0;
      c_rd <= 1'b0; c_stp <= 1'b0; remain <= '0; c_len <= '0; tgt <= '0;
      res <= RES_OK; tmo_cnt <= '0; run_pend <= 1'b0; busy <= 1'b0;
      bus_held <= 1'b0; scl_lo <= 1'b0; sda_lo <= 1'b0;
      {ev_ok, ev_nodev, ev_nack, ev_arb, ev_tout} <= '0;
    end else begin
      {ev_ok, ev_nodev, ev_nack, ev_arb, ev_tout} <= '0;
      if (!stall) tmo_cnt <= '0;
      else if (!tmo_dis) tmo_cnt <= tmo_cnt + 1'b1;

      if (cfg_take) begin
        run_pend <= cfg_word[31] && (cfg_word[CNT_W-1:0] != '0);
        c_len    <= cfg_word[CNT_W-1:0];
        c_rd     <= cfg_word[16];
        c_stp    <= cfg_word[17];
      end

      case (st)
        S_IDLE: if (run_pend) begin
          run_pend <= 1'b0;
          busy     <= 1'b1;
          tgt      <= addr_word[16:10];
          rd       <= c_rd;
          stp      <= c_stp;
          remain   <= c_len;
          res      <= RES_OK;
          ph       <= '0;
          st       <= S_START;
        end

        S_START: if (tick) begin
          ph <= ph + 1'b1;
          case (ph)
            2'd0: sda_lo <= 1'b0;
            2'd1: scl_lo <= 1'b0;
            2'd2: sda_lo <= 1'b1;
            default: begin
              scl_lo   <= 1'b1;
              bus_held <= 1'b0;
              sh       <= {tgt, rd};
              is_addr  <= 1'b1;
              bitn     <= '0;
              st       <= S_BIT;
            end
          endcase
        end

        S_BIT: if (tick) begin
          ph <= ph + 1'b1;
          case (ph)
            2'd0: begin
              own    <= mdrv;
              sda_lo <= mdrv && mlow;
            end
            2'd1: scl_lo <= 1'b0;
            2'd2: begin
              if (own && !sda_lo && !sda_i) begin
                scl_lo <= 1'b0;
                sda_lo <= 1'b0;
                busy   <= 1'b0;
                ev_arb <= 1'b1;
                ph     <= '0;
                st     <= S_IDLE;
              end else if (data_bit) begin
                sh <= {sh[6:0], sda_i};
              end else begin
                nak <= sda_i;
              end
            end
            default: begin
              scl_lo <= 1'b1;
              if (bitn == 4'd7) begin
                bitn <= 4'd8;
                if (!is_addr && rd) st <= S_PUSH;
              end else if (data_bit) begin
                bitn <= bitn + 1'b1;
              end else if (is_addr) begin
                if (nak) begin
                  res <= RES_NODEV;
                  st  <= S_STOP;
                end else begin
                  is_addr <= 1'b0;
                  bitn    <= '0;
                  if (!rd) st <= S_LOAD;
                end
              end else if (!rd && nak) begin
                res <= RES_NACK;
                st  <= S_STOP;
              end else begin
                remain <= remain - 1'b1;
                bitn   <= '0;
                if (last) begin
                  if (stp) st <= S_STOP;
                  else begin
                    sda_lo   <= 1'b0;
                    bus_held <= 1'b1;
                    busy     <= 1'b0;
                    ev_ok    <= 1'b1;
                    st       <= S_IDLE;
                  end
                end else if (!rd) begin
                  st <= S_LOAD;
                end
              end
            end
          endcase
        end

        S_LOAD: begin
          if (!tx_empty) begin
            sh   <= tx_data;
            bitn <= '0;
            ph   <= '0;
            st   <= S_BIT;
          end else if (tmo_hit) begin
            res <= RES_TOUT;
            ph  <= '0;
            st  <= S_STOP;
          end
        end

        S_PUSH: begin
          if (!rx_full) begin
            ph <= '0;
            st <= S_BIT;
          end else if (tmo_hit) begin
            res <= RES_TOUT;
            ph  <= '0;
            st  <= S_STOP;
          end
        end

        S_STOP: if (tick) begin
          ph <= ph + 1'b1;
          case (ph)
            2'd0: begin scl_lo <= 1'b1; sda_lo <= 1'b1; end
            2'd1: scl_lo <= 1'b0;
            2'd2: sda_lo <= 1'b0;
            default: begin
              busy     <= 1'b0;
              ev_ok    <= (res == RES_OK);
              ev_nodev <= (res == RES_NODEV);
              ev_nack  <= (res == RES_NACK);
              ev_tout  <= (res == RES_TOUT);
              st       <= S_IDLE;
            end
          endcase
        end

        default: st <= S_IDLE;
      endcase
    end
  end

  wire any_ev = ev_ok | ev_nodev | ev_nack | ev_arb | ev_tout;

  assert_one_event_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_ok, ev_nodev, ev_nack, ev_arb, ev_tout}));
  assert_busy_end_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(srst)) |-> any_ev);
  assert_event_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    any_ev |-> !busy);
  assert_run_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !run_pend);
  assert_clock_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> scl_lo);
  assert_pop_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (busy && !rd));
  assert_push_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (busy && rd));
  assert_stop_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ok && !bus_held) |-> (!scl_lo && !sda_lo));
  assert_hold_scl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ok && bus_held) |-> (scl_lo && !sda_lo));
  assert_nodev_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nodev |-> (!scl_lo && !sda_lo && !bus_held));
  assert_nack_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nack |-> (!scl_lo && !sda_lo && !bus_held));
  assert_arb_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb |-> (!scl_lo && !sda_lo && !bus_held));
  assert_srst_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(srst) |-> (!busy && !run_pend && !scl_lo && !sda_lo));
endmodule

// File: tb/tb_i2c_auto_master.sv
module tb_i2c_auto_master;
  localparam int CLK_P = 10;
  localparam logic [6:0] SLV = 7'h6A;

  logic clk = 0, rst_n = 0, srst = 0, cfg_we = 0, tmo_dis = 0, tick = 0;
  logic [31:0] cfg_word = '0, addr_word = '0;
  logic rx_block = 0;
  logic tx_pop, rx_push, scl_lo, sda_lo, busy, run_pend, bus_held;
  logic ev_ok, ev_nodev, ev_nack, ev_arb, ev_tout;
  logic [7:0] rx_data;
  logic [7:0] tx_mem [16];
  int tx_rd = 0, tx_cnt = 0, rx_n = 0;
  logic [7:0] rx_got [16];
  int n_chk = 0, n_fail = 0, n_ev = 0;
  bit finished = 0;

  logic s_lo = 0;
  wire scl_line = ~scl_lo;
  wire sda_line = ~(sda_lo | s_lo);
  wire tx_empty = (tx_rd >= tx_cnt);

  always #(CLK_P/2) clk = ~clk;

  i2c_auto_master dut (
    .clk(clk), .rst_n(rst_n), .srst(srst), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .addr_word(addr_word), .tmo_dis(tmo_dis), .tick(tick),
    .tx_data(tx_mem[tx_rd[3:0]]), .tx_empty(tx_empty), .tx_pop(tx_pop),
    .rx_data(rx_data), .rx_full(rx_block), .rx_push(rx_push),
    .sda_i(sda_line), .scl_lo(scl_lo), .sda_lo(sda_lo), .busy(busy),
    .run_pend(run_pend), .bus_held(bus_held), .ev_ok(ev_ok), .ev_nodev(ev_nodev),
    .ev_nack(ev_nack), .ev_arb(ev_arb), .ev_tout(ev_tout));

  always @(posedge clk) tick <= rst_n ? ~tick : 1'b0;
  always @(posedge clk) if (tx_pop) tx_rd <= tx_rd + 1;
  always @(posedge clk) if (rx_push) begin rx_got[rx_n[3:0]] <= rx_data; rx_n <= rx_n + 1; end
  always @(negedge clk) n_ev += int'(ev_ok) + int'(ev_nodev) + int'(ev_nack) + int'(ev_arb) + int'(ev_tout);

  function automatic logic [7:0] tp(int i); return 8'(i * 71 + 5); endfunction
  function automatic logic [7:0] rp(int i); return 8'(i * 53 + 17); endfunction

  // bus target model
  bit slv_on = 0, fresh = 0, rw = 0, addr_nak = 0, arb_mode = 0;
  int bitn = 0, sph = 3, wr_cnt = 0, rd_idx = 0, nack_at = -1, starts = 0, stops = 0;
  logic [7:0] ssh = 0;
  logic [7:0] wr_got [16];
  logic mack [16];

  always @(negedge sda_line) if (slv_on && scl_line === 1'b1) begin
    starts++; fresh = 1; sph = 0; bitn = 0; s_lo = 0;
  end
  always @(posedge sda_line) if (slv_on && scl_line === 1'b1) begin
    stops++; sph = 3;
  end
  always @(posedge scl_line) if (slv_on && sph != 3 && !fresh) begin
    if (bitn < 8) ssh = {ssh[6:0], sda_line};
    else if (sph == 2) begin
      mack[rd_idx[3:0]] = sda_line; rd_idx++;
      if (sda_line) sph = 3;
    end
  end
  always @(negedge scl_line) if (slv_on && sph != 3) begin
    logic [7:0] rb;
    if (fresh) begin fresh = 0; bitn = 0; end
    else if (bitn == 7) begin
      bitn = 8;
      if (sph == 0) begin rw = ssh[0]; s_lo = (ssh[7:1] == SLV) && !addr_nak; end
      else if (sph == 1) begin wr_got[wr_cnt[3:0]] = ssh; s_lo = (wr_cnt != nack_at); wr_cnt++; end
      else s_lo = 0;
    end else if (bitn == 8) begin
      bitn = 0; s_lo = 0;
      if (sph == 0) sph = ((ssh[7:1] == SLV) && !addr_nak) ? (rw ? 2 : 1) : 3;
      else if (sph == 1 && wr_cnt - 1 == nack_at) sph = 3;
    end else bitn++;
    if (sph == 2 && bitn < 8) begin rb = rp(rd_idx); s_lo = ~rb[7 - bitn]; end
    if (arb_mode && sph == 0 && bitn == 1) s_lo = 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int len, input bit rdb, input bit stpb, input bit run);
    @(negedge clk);
    cfg_word = {run, 13'b0, stpb, rdb, 16'(len)};
    cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wait_ev(input int lim, output int code);
    code = -1;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (ev_ok) begin code = 0; break; end
      if (ev_nodev) begin code = 1; break; end
      if (ev_nack) begin code = 2; break; end
      if (ev_arb) begin code = 3; break; end
      if (ev_tout) begin code = 4; break; end
    end
  endtask

  task automatic prep(input int len, input int avail);
    @(negedge clk);
    for (int k = 0; k < 16; k++) tx_mem[k] = tp(k);
    tx_rd = 0; tx_cnt = avail; rx_n = 0; wr_cnt = 0; rd_idx = 0;
  endtask

  task automatic slave_release();
    s_lo = 0; sph = 3; arb_mode = 0; addr_nak = 0; nack_at = -1;
  endtask

  task automatic set_addr(input logic [6:0] a);
    addr_word = {12'hFFF, 3'b101, a, 10'h3FF};
  endtask

  initial begin
    int code, e0, st0, sp0;
    bit prev_held;
    set_addr(SLV);
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    slv_on = 1;
    chk("R2 reset busy", int'(busy), 0);
    chk("R2 reset run_pend", int'(run_pend), 0);
    chk("R6 reset scl released", int'(scl_line), 1);
    chk("R6 reset sda released", int'(sda_line), 1);

    prev_held = 0;
    for (int rdb = 0; rdb < 2; rdb++)
      for (int stpb = 0; stpb < 2; stpb++)
        for (int len = 1; len <= 5; len++) begin
          prep(len, len);
          e0 = n_ev; st0 = starts; sp0 = stops;
          cfg(len, rdb[0], stpb[0], 1);
          chk("R2 run_pend after write", int'(run_pend), 1);
          chk("R2 busy not yet", int'(busy), 0);
          @(negedge clk);
          chk("R2 run_pend self-clears", int'(run_pend), 0);
          chk("R2 busy at start", int'(busy), 1);
          wait_ev(6000, code);
          chk(rdb ? "R5 read outcome ok" : "R4 write outcome ok", code, 0);
          chk("R13 busy low at outcome", int'(busy), 0);
          if (rdb == 0) begin
            chk("R4 bytes seen by target", wr_cnt, len);
            chk("R4 bytes popped", tx_rd, len);
            for (int k = 0; k < len; k++) chk("R4 byte value", int'(wr_got[k]), int'(tp(k)));
          end else begin
            chk("R5 bytes pushed", rx_n, len);
            for (int k = 0; k < len; k++) begin
              chk("R5 byte value", int'(rx_got[k]), int'(rp(k)));
              chk("R5 master ack pattern", int'(mack[k]), (k == len - 1) ? 1 : 0);
            end
          end
          chk(prev_held ? "R7 repeated start" : "R1 start seen", starts, st0 + 1);
          if (stpb) begin
            chk("R6 stop seen", stops, sp0 + 1);
            chk("R6 scl released", int'(scl_line), 1);
            chk("R6 sda released", int'(sda_line), 1);
            chk("R6 not held", int'(bus_held), 0);
          end else begin
            chk("R7 no stop", stops, sp0);
            chk("R7 scl held low", int'(scl_line), 0);
            chk("R7 sda released", int'(sda_line), 1);
            chk("R7 bus_held", int'(bus_held), 1);
          end
          repeat (20) @(negedge clk);
          chk("R13 single outcome", n_ev, e0 + 1);
          prev_held = !stpb;
        end

    // R3 zero count
    e0 = n_ev; st0 = starts;
    cfg(0, 0, 1, 1);
    chk("R3 zero count no run_pend", int'(run_pend), 0);
    repeat (100) @(negedge clk);
    chk("R3 zero count not busy", int'(busy), 0);
    chk("R3 zero count no start", starts, st0);
    chk("R3 zero count no outcome", n_ev, e0);

    // R1 write ignored while busy
    prep(2, 2);
    e0 = n_ev; st0 = starts;
    cfg(2, 0, 1, 1);
    repeat (30) @(negedge clk);
    cfg(3, 1, 1, 1);
    chk("R1 write while busy ignored", int'(run_pend), 0);
    wait_ev(6000, code);
    chk("R1 original transfer ok", code, 0);
    chk("R1 original length kept", wr_cnt, 2);
    repeat (200) @(negedge clk);
    chk("R1 no second transfer", starts, st0 + 1);
    chk("R1 one outcome", n_ev, e0 + 1);

    // R8 address not acknowledged
    set_addr(7'h11);
    prep(2, 2); sp0 = stops;
    cfg(2, 0, 1, 1);
    wait_ev(6000, code);
    chk("R8 nodev outcome", code, 1);
    chk("R8 stop seen", stops, sp0 + 1);
    chk("R8 nothing popped", tx_rd, 0);
    set_addr(SLV);

    // R9 data not acknowledged
    prep(4, 4); nack_at = 1; sp0 = stops;
    cfg(4, 0, 1, 1);
    wait_ev(6000, code);
    chk("R9 nack outcome", code, 2);
    chk("R9 popped up to refused byte", tx_rd, 2);
    chk("R9 stop seen", stops, sp0 + 1);
    chk("R9 lines released", int'(scl_line & sda_line), 1);
    nack_at = -1;

    // R10 arbitration lost
    prep(1, 1); arb_mode = 1;
    cfg(1, 0, 1, 1);
    wait_ev(6000, code);
    chk("R10 arbitration outcome", code, 3);
    chk("R10 scl released", int'(scl_line), 1);
    chk("R10 master sda released", int'(sda_lo), 0);
    chk("R10 busy low", int'(busy), 0);
    slave_release();
    repeat (10) @(negedge clk);

    // R11 timeout enabled
    tmo_dis = 0;
    prep(2, 1); sp0 = stops;
    cfg(2, 0, 1, 1);
    repeat (250) @(negedge clk);
    chk("R11 stall holds scl low", int'(scl_line), 0);
    wait_ev(6000, code);
    chk("R11 timeout outcome", code, 4);
    chk("R11 one byte sent", wr_cnt, 1);
    chk("R11 stop after timeout", stops, sp0 + 1);

    // R11 timeout disabled, tx stall
    tmo_dis = 1;
    prep(2, 1); e0 = n_ev;
    cfg(2, 0, 1, 1);
    repeat (1200) @(negedge clk);
    chk("R11 disabled timeout still busy", int'(busy), 1);
    chk("R11 disabled timeout no outcome", n_ev, e0);
    chk("R11 scl held during stall", int'(scl_line), 0);
    tx_cnt = 2;
    wait_ev(6000, code);
    chk("R11 resumes ok", code, 0);
    chk("R11 second byte value", int'(wr_got[1]), int'(tp(1)));

    // R11 rx full stall
    prep(2, 0); rx_block = 1;
    cfg(2, 1, 1, 1);
    repeat (800) @(negedge clk);
    chk("R11 rx stall nothing pushed", rx_n, 0);
    chk("R11 rx stall busy", int'(busy), 1);
    rx_block = 0;
    wait_ev(6000, code);
    chk("R11 rx resumes ok", code, 0);
    chk("R11 rx byte1", int'(rx_got[1]), int'(rp(1)));
    tmo_dis = 0;

    // R12 soft reset
    prep(4, 4); e0 = n_ev;
    cfg(4, 0, 1, 1);
    repeat (100) @(negedge clk);
    srst = 1;
    @(negedge clk);
    srst = 0;
    slave_release();
    chk("R12 busy cleared", int'(busy), 0);
    chk("R12 run_pend cleared", int'(run_pend), 0);
    chk("R12 scl released", int'(scl_line), 1);
    chk("R12 sda released", int'(sda_line), 1);
    repeat (200) @(negedge clk);
    chk("R12 no outcome", n_ev, e0);

    prep(2, 0);
    cfg(2, 1, 1, 1);
    wait_ev(6000, code);
    chk("R12 recovery read ok", code, 0);
    chk("R12 recovery byte0", int'(rx_got[0]), int'(rp(0)));

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule